// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block turns the operand fields of a load or store instruction into the memory address that instruction will use. The decoder supplies four things: a 3-bit addressing-mode code, two flags that mark the instruction as a load/store or as a branch, the register-file values the mode needs, and the displacement or absolute field from the instruction word. The block registers the address and drives a one-cycle strobe that the memory interface can use.

Memory addresses are `ADDR_W` bits wide (21 by default), which is wider than the `DATA_W`-bit data path. Only the far-relative mode reaches above the low 64 KiB. It builds a base from two adjacent registers and adds the sign-extended displacement modulo 2^`ADDR_W`. The relative, absolute and PC-relative forms are computed on the data path and then zero-extended.

Immediate-mode branches share the same adder style. For these the block registers `pc_i` plus the displacement as a branch target with its own strobe. Register-mode and non-branch immediate operands never produce a strobe.

Top module: `lsu_addr_gen`

## Requirements
- R1: During and right after reset, `mem_valid_o` and `br_valid_o` are 0, and `mem_addr_o` and `br_target_o` are all zeros.
- R2: Relative mode (code 2) with a load/store request yields `mem_addr_o` = zero-extended (`reg_lo_i` + `disp_i`) mod 2^DATA_W, one cycle after the request.
- R3: Far-relative mode (code 3) yields `mem_addr_o` = ({`pair_hi_i`, `reg_lo_i`} + `disp_i` sign-extended to ADDR_W) mod 2^ADDR_W. `pair_hi_i` holds the low ADDR_W-DATA_W bits of the higher-numbered register and forms the top bits of the base.
- R4: Absolute mode (code 4) yields `mem_addr_o` = `disp_i` zero-extended to ADDR_W, one cycle after the request.
- R5: Immediate mode (code 1) with `is_branch_i` set raises `br_valid_o` one cycle later, with `br_target_o` = (`pc_i` + `disp_i`) mod 2^DATA_W.
- R6: `mem_valid_o` is high exactly one cycle after a cycle with `req_i`, `is_mem_i` and a mode code of 2, 3 or 4. Register mode (code 0) and immediate mode never raise it.
- R7: A request in a memory mode without `is_mem_i` raises no strobe and leaves `mem_addr_o` unchanged.
- R8: `mem_addr_o` holds its value in every cycle where `mem_valid_o` is low, and `br_target_o` holds its value in every cycle where `br_valid_o` is low.
- R9: `is_branch_i` is ignored outside immediate mode. In immediate mode `is_mem_i` causes no memory access, so the two strobes are never high together.
- R10: Mode codes 5, 6 and 7 raise neither strobe and change neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Operand request this cycle |
| mode_i | input | 3 | Addressing-mode code (0 register, 1 immediate, 2 relative, 3 far-relative, 4 absolute) |
| is_mem_i | input | 1 | Instruction is a load or store |
| is_branch_i | input | 1 | Instruction is a branch |
| reg_lo_i | input | DATA_W | Base register value (the lower-numbered register of the pair in far mode) |
| pair_hi_i | input | ADDR_W-DATA_W | Low bits of the higher-numbered register of the pair |
| disp_i | input | DATA_W | Displacement or absolute field |
| pc_i | input | DATA_W | Current program counter |
| mem_addr_o | output | ADDR_W | Registered memory address |
| mem_valid_o | output | 1 | Memory address strobe |
| br_target_o | output | DATA_W | Registered branch target |
| br_valid_o | output | 1 | Branch target strobe |

## Verification
Two functions can fall in the same cycle: the memory-address path and the branch-target path. This happens when the decoder flags an instruction as both load/store and branch. The bench sweeps every mode code against all four combinations of the two flags, with and without `req_i`. For each vector it judges both strobes and both held outputs against its own arithmetic model. The far-relative carry into the top bits and the wrap at 2^21 are provoked with corner operands: an all-ones base, zero bases and ±1 displacements.

// File: rtl/agen_pkg.sv
package agen_pkg;

   typedef enum logic [2:0] {
      AM_REG = 3'd0,
      AM_IMM = 3'd1,
      AM_REL = 3'd2,
      AM_FAR = 3'd3,
      AM_ABS = 3'd4
   } agen_mode_e;

endpackage

// File: rtl/agen_add.sv
// Wrapping adder used for every address sum.
module agen_add #(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] sum_o
);
   always_comb sum_o = a_i + b_i;
endmodule

// File: rtl/agen_decode.sv
// Qualifies a request into a memory fire or a branch fire.
module agen_decode
   import agen_pkg::*;
#(
   parameter bit FAR_EN = 1'b1
) (
   input  logic       req_i,
   input  logic [2:0] mode_i,
   input  logic       is_mem_i,
   input  logic       is_branch_i,
   output logic       mem_fire_o,
   output logic       br_fire_o,
   output logic [1:0] addr_sel_o
);
   logic far_ok;

   generate
      if (FAR_EN) begin : g_far_on
         assign far_ok = 1'b1;
      end else begin : g_far_off
         assign far_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      mem_fire_o = 1'b0;
      br_fire_o  = 1'b0;
      addr_sel_o = 2'd0;
      if (req_i) begin
         case (mode_i)
            AM_IMM: br_fire_o = is_branch_i;
            AM_REL: begin
               mem_fire_o = is_mem_i;
               addr_sel_o = 2'd0;
            end
            AM_FAR: begin
               mem_fire_o = is_mem_i & far_ok;
               addr_sel_o = 2'd1;
            end
            AM_ABS: begin
               mem_fire_o = is_mem_i;
               addr_sel_o = 2'd2;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/agen_calc.sv
// Forms the three candidate addresses and the branch target.
module agen_calc #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 21
) (
   input  logic [1:0]               sel_i,
   input  logic [DATA_W-1:0]        reg_lo_i,
   input  logic [ADDR_W-DATA_W-1:0] pair_hi_i,
   input  logic [DATA_W-1:0]        disp_i,
   input  logic [DATA_W-1:0]        pc_i,
   output logic [ADDR_W-1:0]        addr_o,
   output logic [DATA_W-1:0]        tgt_o
);
   localparam int HI_W = ADDR_W - DATA_W;

   logic [DATA_W-1:0] rel_sum;
   logic [ADDR_W-1:0] far_base, far_disp, far_sum;

   assign far_base = {pair_hi_i, reg_lo_i};
   assign far_disp = {{HI_W{disp_i[DATA_W-1]}}, disp_i};

   agen_add #(.W(DATA_W)) u_rel (.a_i(reg_lo_i), .b_i(disp_i), .sum_o(rel_sum));
   agen_add #(.W(ADDR_W)) u_far (.a_i(far_base), .b_i(far_disp), .sum_o(far_sum));
   agen_add #(.W(DATA_W)) u_pcr (.a_i(pc_i),     .b_i(disp_i), .sum_o(tgt_o));

   always_comb begin
      case (sel_i)
         2'd1:    addr_o = far_sum;
         2'd2:    addr_o = {{HI_W{1'b0}}, disp_i};
         default: addr_o = {{HI_W{1'b0}}, rel_sum};
      endcase
   end
endmodule

// File: rtl/agen_stage.sv
// Output registers; values load only when their strobe fires.
module agen_stage #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_fire_i,
   input  logic              br_fire_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] tgt_i,
   output logic [ADDR_W-1:0] addr_q,
   output logic              mem_vld_q,
   output logic [DATA_W-1:0] tgt_q,
   output logic              br_vld_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q    <= '0;
         mem_vld_q <= 1'b0;
         tgt_q     <= '0;
         br_vld_q  <= 1'b0;
      end else begin
         mem_vld_q <= mem_fire_i;
         br_vld_q  <= br_fire_i;
         if (mem_fire_i) addr_q <= addr_i;
         if (br_fire_i)  tgt_q  <= tgt_i;
      end
   end

   // R8: held outputs do not move without their strobe.
   a_r8_tgt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !br_vld_q |-> $stable(tgt_q));
endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
   import agen_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 21,
   parameter bit FAR_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_i,
   input  logic [2:0]               mode_i,
   input  logic                     is_mem_i,
   input  logic                     is_branch_i,
   input  logic [DATA_W-1:0]        reg_lo_i,
   input  logic [ADDR_W-DATA_W-1:0] pair_hi_i,
   input  logic [DATA_W-1:0]        disp_i,
   input  logic [DATA_W-1:0]        pc_i,
   output logic [ADDR_W-1:0]        mem_addr_o,
   output logic                     mem_valid_o,
   output logic [DATA_W-1:0]        br_target_o,
   output logic                     br_valid_o
);
   localparam int HI_W = ADDR_W - DATA_W;

   generate
      if (DATA_W < 2) begin : g_chk_dw
         $error("DATA_W too small");
      end
      if (HI_W < 1 || HI_W > DATA_W) begin : g_chk_aw
         $error("ADDR_W must exceed DATA_W by 1..DATA_W bits");
      end
   endgenerate

   logic              mem_fire, br_fire;
   logic [1:0]        addr_sel;
   logic [ADDR_W-1:0] addr_c;
   logic [DATA_W-1:0] tgt_c;

   agen_decode #(.FAR_EN(FAR_EN)) u_dec (
      .req_i(req_i), .mode_i(mode_i), .is_mem_i(is_mem_i),
      .is_branch_i(is_branch_i), .mem_fire_o(mem_fire),
      .br_fire_o(br_fire), .addr_sel_o(addr_sel)
   );

   agen_calc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_calc (
      .sel_i(addr_sel), .reg_lo_i(reg_lo_i), .pair_hi_i(pair_hi_i),
      .disp_i(disp_i), .pc_i(pc_i), .addr_o(addr_c), .tgt_o(tgt_c)
   );

   agen_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_stg (
      .clk(clk), .rst_n(rst_n), .mem_fire_i(mem_fire), .br_fire_i(br_fire),
      .addr_i(addr_c), .tgt_i(tgt_c), .addr_q(mem_addr_o),
      .mem_vld_q(mem_valid_o), .tgt_q(br_target_o), .br_vld_q(br_valid_o)
   );

   // R6: a memory strobe needs a qualifying load/store request.
   a_r6_mem_needs_ls: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid_o |-> $past(req_i && is_mem_i &&
         (mode_i == AM_REL || mode_i == AM_FAR || mode_i == AM_ABS)));
   // R5: an immediate branch gets its target strobe.
   a_r5_branch_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && is_branch_i && mode_i == AM_IMM) |=> br_valid_o);
   // R4: absolute address is the field, zero-extended.
   a_r4_abs_field: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && is_mem_i && mode_i == AM_ABS) |=>
         (mem_addr_o == {{HI_W{1'b0}}, $past(disp_i)}));
   // R9: the two strobes never coincide.
   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_valid_o && br_valid_o));
   // R8: address output holds without a strobe.
   a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_valid_o |-> $stable(mem_addr_o));
   // R10: undefined codes raise nothing.
   a_r10_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && mode_i > 3'd4) |=> (!mem_valid_o && !br_valid_o));
endmodule

// File: tb/lsu_addr_gen_tb.sv
module lsu_addr_gen_tb;
   localparam int DW = 16;
   localparam int AW = 21;
   localparam int HW = AW - DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_i = 1'b0;
   logic [2:0]    mode_i = '0;
   logic          is_mem_i = 1'b0, is_branch_i = 1'b0;
   logic [DW-1:0] reg_lo_i = '0, disp_i = '0, pc_i = '0;
   logic [HW-1:0] pair_hi_i = '0;
   logic [AW-1:0] mem_addr_o;
   logic          mem_valid_o, br_valid_o;
   logic [DW-1:0] br_target_o;

   int n_vec = 0, n_bad = 0;
   logic [AW-1:0] e_addr = '0;
   logic [DW-1:0] e_tgt = '0;
   logic [31:0]   seed = 32'h1234_5678;

   always #5 clk = ~clk;

   lsu_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
      .is_mem_i(is_mem_i), .is_branch_i(is_branch_i), .reg_lo_i(reg_lo_i),
      .pair_hi_i(pair_hi_i), .disp_i(disp_i), .pc_i(pc_i),
      .mem_addr_o(mem_addr_o), .mem_valid_o(mem_valid_o),
      .br_target_o(br_target_o), .br_valid_o(br_valid_o)
   );

   function automatic logic [31:0] lcg(input logic [31:0] s);
      return s * 32'd1664525 + 32'd1013904223;
   endfunction

   task automatic judge(input string tag, input logic mv, input logic bv);
      n_vec++;
      if (mem_valid_o !== mv || br_valid_o !== bv ||
          mem_addr_o !== e_addr || br_target_o !== e_tgt) begin
         n_bad++;
         $display("FAIL %s: mv=%0b bv=%0b addr=%h tgt=%h expected mv=%0b bv=%0b addr=%h tgt=%h",
                  tag, mem_valid_o, br_valid_o, mem_addr_o, br_target_o,
                  mv, bv, e_addr, e_tgt);
      end
   endtask

   task automatic step(input logic rq, input logic [2:0] md, input logic m,
                       input logic b, input logic [DW-1:0] lo,
                       input logic [HW-1:0] hi, input logic [DW-1:0] d,
                       input logic [DW-1:0] pc);
      logic mv, bv;
      string tag;
      req_i = rq; mode_i = md; is_mem_i = m; is_branch_i = b;
      reg_lo_i = lo; pair_hi_i = hi; disp_i = d; pc_i = pc;
      mv = rq && m && (md == 3'd2 || md == 3'd3 || md == 3'd4);
      bv = rq && b && (md == 3'd1);
      if (mv) begin
         case (md)
            3'd2:    e_addr = {{HW{1'b0}}, DW'(lo + d)};
            3'd3:    e_addr = AW'({hi, lo} + {{HW{d[DW-1]}}, d});
            default: e_addr = {{HW{1'b0}}, d};
         endcase
      end
      if (bv) e_tgt = DW'(pc + d);
      if (!rq)                           tag = "R8";
      else if (md > 3'd4)                tag = "R10";
      else if (md == 3'd0)               tag = "R6";
      else if (md == 3'd1)               tag = (m && b) ? "R9" : "R5";
      else if (!m)                       tag = "R7";
      else if (b)                        tag = "R9";
      else if (md == 3'd2)               tag = "R2";
      else if (md == 3'd3)               tag = "R3";
      else                               tag = "R4";
      @(negedge clk);
      req_i = 1'b0;
      judge(tag, mv, bv);
   endtask

   initial begin : watchdog
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      logic [DW-1:0] lo, d, pc;
      logic [HW-1:0] hi;
      repeat (3) @(negedge clk);
      judge("R1", 1'b0, 1'b0);        // R1: reset state
      rst_n = 1'b1;
      @(negedge clk);
      judge("R1", 1'b0, 1'b0);        // R1: right after reset
      for (int k = 0; k < 24; k++) begin
         case (k)
            0: begin lo = 16'hFFFF; hi = 5'h1F; d = 16'h0001; pc = 16'hFFFF; end
            1: begin lo = 16'h0000; hi = 5'h00; d = 16'hFFFF; pc = 16'h0000; end
            2: begin lo = 16'hFFFF; hi = 5'h03; d = 16'h0001; pc = 16'h8000; end
            3: begin lo = 16'h0000; hi = 5'h10; d = 16'h8000; pc = 16'h7FFF; end
            default: begin
               seed = lcg(seed); lo = seed[31:16]; hi = seed[4:0];
               seed = lcg(seed); d = seed[31:16]; pc = seed[15:0];
            end
         endcase
         for (int md = 0; md < 8; md++)
            for (int fl = 0; fl < 8; fl++)
               step(fl[2], 3'(md), fl[0], fl[1], lo, hi, d, pc);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule